// File: doc/BRIEF.md
# Pipelined Burst SRAM Controller

This block is a synchronous single-port memory of 32-bit words with a registered command stage and a registered read-data stage. At every rising clock edge it samples two address strobes (a processor strobe and a controller strobe), an advance input, three chip selects, the write controls and the address, then decides whether to start a new access, continue the current four-beat burst, or go deselected. Writes update the internal array under a per-byte mask. Reads return their word one clock after the address was sampled. A drive flag, gated without a clock by an active-low output enable, stands in for a bidirectional data bus.

A new access loads the address. Later cycles with no strobe walk the two low address bits through a four-beat burst that wraps. The walk is either linear or interleaved, chosen by a static order input. A cycle that raises the advance input holds the burst address, so a read repeats or a write lands on the same word again. A processor-started access is always a read. The controller strobe starts either a read or a write.

Top module: `bsram_core`

## Requirements
- R1: A read sampled at clock edge E returns the word at its address on `rdata` after edge E+1, with `rdrive` high while `oe_n` is low.
- R2: An access starts only when a strobe is honoured at the edge and `sel1_n`=0, `sel2`=1 and `sel3_n`=0 all hold together.
- R3: While `sel1_n` is high, a low `strobe_p_n` is ignored. A cycle with only that strobe low behaves as a no-strobe cycle: an active burst continues and nothing restarts.
- R4: When both strobes are low, only the processor strobe takes effect. A processor-started access is a read whatever `gw_n`, `bwe_n` and `bsel_n` are, and it writes nothing.
- R5: A controller-started or continuing cycle is a write when `gw_n`=0 or `bwe_n`=0, and a read when both are high. A write cycle leaves `rdrive` low after the next edge.
- R6: `gw_n`=0 writes all four bytes, regardless of `bwe_n` and `bsel_n`.
- R7: With `gw_n`=1 and `bwe_n`=0, byte lane i (bits 8i+7..8i) is written only when `bsel_n[i]`=0. Every other lane keeps its old contents.
- R8: On a cycle with no honoured strobe and `adv_n`=0 during an active burst, the step count k advances mod 4. The upper address bits stay fixed. The low two bits become start+k mod 4 when `lin_order`=1, and start XOR k when `lin_order`=0.
- R9: On a cycle with no honoured strobe and `adv_n`=1 during an active burst, the address is held, so a read repeats the same word or a write hits the same word again.
- R10: A strobe cycle whose chip selects are not all active deselects the block. The output after the following edge is not driven, and later no-strobe cycles perform no access.
- R11: `oe_n` high forces `rdrive` low at once, with no clock edge.
- R12: Synchronous reset `rst` leaves the block deselected with `rdrive` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lin_order | input | 1 | Static burst order: 1 linear, 0 interleaved |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low, writes all bytes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| addr | input | AW (8) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rdrive | output | 1 | Read data is valid and driven |

## Verification
The bench fills the whole array and then mixes directed sequences with seeded random traffic, checked against a bench model of the access rules. The corner cases it targets are these:
- Both strobes low with global write low. A design without processor priority would write and drop the read.
- The processor strobe with select 1 high in the middle of a burst. A design that honours it would restart the burst at a new address.
- Linear and interleaved walks that start at odd offsets and wrap. A wrong order returns words from the wrong addresses.
- A read that follows a deselect. A design that keeps stale output would raise the drive flag too early.

Partial byte writes, suspended bursts and `oe_n` raised in mid-cycle are also checked. Each would show up as corrupted lanes, a skipped word, or a drive flag that waits for a clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int DATA_W    = 32;
    localparam int NBYTE     = DATA_W / 8;
    localparam int BURST_W   = 2;
    localparam int DEF_DEPTH = 256;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [NBYTE-1:0]  be;
        logic [DATA_W-1:0] wd;
    } acc_t;

    // burst offset for step k from start offset s
    function automatic logic [BURST_W-1:0] burst_off(
        input logic [BURST_W-1:0] s,
        input logic [BURST_W-1:0] k,
        input logic               lin
    );
        return lin ? (s + k) : (s ^ k);
    endfunction

    // byte lanes touched by a write cycle
    function automatic logic [NBYTE-1:0] lane_mask(
        input logic             gw_n,
        input logic             bwe_n,
        input logic [NBYTE-1:0] bsel_n
    );
        if (!gw_n)
            return {NBYTE{1'b1}};
        else if (!bwe_n)
            return ~bsel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/bsram_select.sv
module bsram_select (
    input  logic strobe_p_n,
    input  logic strobe_c_n,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    output logic start,
    output logic desel,
    output logic force_rd
);
    logic p_taken;
    logic any_strobe;
    logic chip_on;

    always_comb begin
        p_taken    = !strobe_p_n && !sel1_n;
        any_strobe = p_taken || !strobe_c_n;
        chip_on    = !sel1_n && sel2 && !sel3_n;
        start      = any_strobe && chip_on;
        desel      = any_strobe && !chip_on;
        force_rd   = p_taken;
    end
endmodule

// File: rtl/bsram_issue.sv
module bsram_issue
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              desel,
    input  logic              force_rd,
    input  logic              lin_order,
    input  logic              adv_n,
    input  logic [AW-1:0]     addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTE-1:0]  bsel_n,
    input  logic [DATA_W-1:0] wdata,
    output acc_t              iss,
    output logic [AW-1:0]     iss_addr
);
    localparam int HI_W = AW - BURST_W;

    logic               active;
    logic [HI_W-1:0]    base_hi;
    logic [BURST_W-1:0] start_off;
    logic [BURST_W-1:0] step;

    logic [BURST_W-1:0] step_nx;
    logic [AW-1:0]      addr_nx;
    op_e                op_nx;
    logic               is_rd;

    always_comb begin
        is_rd   = gw_n && bwe_n;
        step_nx = step;
        addr_nx = {base_hi, burst_off(start_off, step, lin_order)};
        op_nx   = OP_NONE;
        if (start) begin
            addr_nx = addr;
            op_nx   = (force_rd || is_rd) ? OP_READ : OP_WRITE;
        end else if (!desel && active) begin
            if (!adv_n)
                step_nx = step + 1'b1;
            addr_nx = {base_hi, burst_off(start_off, step_nx, lin_order)};
            op_nx   = is_rd ? OP_READ : OP_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            base_hi   <= '0;
            start_off <= '0;
            step      <= '0;
        end else if (start) begin
            active    <= 1'b1;
            base_hi   <= addr[AW-1:BURST_W];
            start_off <= addr[BURST_W-1:0];
            step      <= '0;
        end else if (desel) begin
            active    <= 1'b0;
        end else if (active) begin
            step      <= step_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss      <= '0;
            iss_addr <= '0;
        end else begin
            iss.op   <= op_nx;
            iss.be   <= lane_mask(gw_n, bwe_n, bsel_n);
            iss.wd   <= wdata;
            iss_addr <= addr_nx;
        end
    end
endmodule

// File: rtl/bsram_store.sv
module bsram_store
    import bsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              iss,
    input  logic [AW-1:0]     iss_addr,
    output logic [DATA_W-1:0] rword,
    output logic              rvalid
);
    logic do_wr;
    logic do_rd;

    assign do_wr = (iss.op == OP_WRITE);
    assign do_rd = (iss.op == OP_READ);

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (do_wr && iss.be[b])
                lane_mem[iss_addr] <= iss.wd[8*b +: 8];
        end

        always_ff @(posedge clk) begin
            if (do_rd)
                lane_q <= lane_mem[iss_addr];
        end

        assign rword[8*b +: 8] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= do_rd;
    end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
    import bsram_pkg::*;
#(
    parameter  int DEPTH = DEF_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lin_order,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTE-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdrive
);
    logic          start;
    logic          desel;
    logic          force_rd;
    acc_t          iss;
    logic [AW-1:0] iss_addr;
    logic          rvalid;

    bsram_select u_sel (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .start      (start),
        .desel      (desel),
        .force_rd   (force_rd)
    );

    bsram_issue #(.AW(AW)) u_iss (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .desel     (desel),
        .force_rd  (force_rd),
        .lin_order (lin_order),
        .adv_n     (adv_n),
        .addr      (addr),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bsel_n    (bsel_n),
        .wdata     (wdata),
        .iss       (iss),
        .iss_addr  (iss_addr)
    );

    bsram_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .iss      (iss),
        .iss_addr (iss_addr),
        .rword    (rdata),
        .rvalid   (rvalid)
    );

    // output enable gates the drive flag without a clock
    assign rdrive = rvalid && !oe_n;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk (
    input logic clk,
    input logic rst,
    input logic strobe_p_n,
    input logic strobe_c_n,
    input logic sel1_n,
    input logic sel2,
    input logic sel3_n,
    input logic gw_n,
    input logic bwe_n,
    input logic oe_n,
    input logic rdrive
);
    logic p_ok;
    logic any_s;
    logic chip_on;

    assign p_ok    = !strobe_p_n && !sel1_n;
    assign any_s   = p_ok || !strobe_c_n;
    assign chip_on = !sel1_n && sel2 && !sel3_n;

    assert_read_returns_R1: assert property (@(posedge clk) disable iff (rst)
        (any_s && chip_on && gw_n && bwe_n) |-> ##2 (rdrive || oe_n));

    assert_proc_is_read_R4: assert property (@(posedge clk) disable iff (rst)
        (p_ok && chip_on) |-> ##2 (rdrive || oe_n));

    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!p_ok && !strobe_c_n && chip_on && !gw_n) |-> ##2 !rdrive);

    assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (any_s && !chip_on) |-> ##2 !rdrive);

    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> !rdrive);
endmodule

bind bsram_core bsram_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .oe_n       (oe_n),
    .rdrive     (rdrive)
);

// File: tb/sim_bsram_core.sv
`timescale 1ns/1ps
module sim_bsram_core;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lin_order = 1'b1;
    logic        strobe_p_n = 1'b1, strobe_c_n = 1'b1, adv_n = 1'b1;
    logic        sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
    logic        gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  bsel_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdrive;

    always #10 clk = ~clk;

    bsram_core u0 (
        .clk(clk), .rst(rst), .lin_order(lin_order),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdrive(rdrive)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // next-cycle stimulus
    logic n_lin = 1, n_sp = 1, n_sc = 1, n_adv = 1, n_s1 = 1, n_s2 = 1, n_s3 = 0;
    logic n_gw = 1, n_bwe = 1, n_oe = 0;
    logic [3:0]  n_bsel = 4'hF;
    logic [AW-1:0] n_addr = '0;
    logic [31:0] n_wd = '0;
    string n_tag = "";
    bit    probe_oe = 0;

    // bench model
    logic [31:0] mm [DEPTH];
    logic          m_act = 0;
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_s = '0, m_k = '0;
    int    r1_op = 0, r2_op = 0;
    logic [31:0] r1_d = '0, r2_d = '0;
    string r1_tag = "R12", r2_tag = "R12";

    function automatic logic [1:0] exp_off(input logic [1:0] s, input logic [1:0] k, input logic lin);
        if (lin) return s + k;
        return s ^ k;
    endfunction

    task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic check_out();
        logic exp_drv;
        exp_drv = (r2_op == 1) && !oe_n;
        n_cmp++;
        if (rdrive !== exp_drv) fail_line(r2_tag, "drive flag", {31'd0, rdrive}, {31'd0, exp_drv});
        if (exp_drv) begin
            n_cmp++;
            if (rdata !== r2_d) fail_line(r2_tag, "read data", rdata, r2_d);
        end
        if (probe_oe && r2_op == 1 && !oe_n) begin
            oe_n = 1'b1;
            #1;
            n_cmp++;
            if (rdrive !== 1'b0) fail_line("R11", "drive with oe high", {31'd0, rdrive}, 32'd0);
            oe_n = 1'b0;
            #1;
        end
    endtask

    task automatic model_edge();
        logic p_ok, any_s, chip_on;
        logic [AW-1:0] a;
        logic [3:0] m;
        int op;
        string tg;
        p_ok    = !n_sp && !n_s1;
        any_s   = p_ok || !n_sc;
        chip_on = !n_s1 && n_s2 && !n_s3;
        op = 0; a = '0; tg = "R2";
        if (any_s && chip_on) begin
            a = n_addr; m_act = 1; m_hi = n_addr[AW-1:2]; m_s = n_addr[1:0]; m_k = 0;
            op = (p_ok || (n_gw && n_bwe)) ? 1 : 2;
            tg = p_ok ? "R4" : (op == 1 ? "R1" : "R5");
        end else if (any_s) begin
            m_act = 0; tg = "R10";
        end else if (m_act) begin
            if (!n_adv) m_k = m_k + 2'd1;
            a  = {m_hi, exp_off(m_s, m_k, n_lin)};
            op = (n_gw && n_bwe) ? 1 : 2;
            tg = n_adv ? "R9" : "R8";
        end
        if (op == 2) begin
            m = !n_gw ? 4'hF : (!n_bwe ? ~n_bsel : 4'h0);
            for (int b = 0; b < 4; b++)
                if (m[b]) mm[a][8*b +: 8] = n_wd[8*b +: 8];
        end
        if (n_tag != "") tg = n_tag;
        r2_op = r1_op; r2_d = r1_d; r2_tag = r1_tag;
        r1_op = op; r1_d = (op == 1) ? mm[a] : 32'd0; r1_tag = tg;
    endtask

    task automatic step();
        @(negedge clk);
        check_out();
        lin_order = n_lin; strobe_p_n = n_sp; strobe_c_n = n_sc; adv_n = n_adv;
        sel1_n = n_s1; sel2 = n_s2; sel3_n = n_s3; gw_n = n_gw; bwe_n = n_bwe;
        bsel_n = n_bsel; oe_n = n_oe; addr = n_addr; wdata = n_wd;
        model_edge();
        @(posedge clk);
    endtask

    task automatic quiet();
        n_sp = 1; n_sc = 1; n_adv = 1; n_s1 = 0; n_s2 = 1; n_s3 = 0;
        n_gw = 1; n_bwe = 1; n_bsel = 4'hF; n_oe = 0; n_tag = "";
    endtask

    task automatic ctrl(input logic [AW-1:0] a, input logic g, input logic bw, input logic [3:0] bs, input logic [31:0] d, input string tg);
        quiet(); n_sc = 0; n_addr = a; n_gw = g; n_bwe = bw; n_bsel = bs; n_wd = d; n_tag = tg;
        step();
    endtask

    task automatic cont(input logic ad, input string tg);
        quiet(); n_adv = ad; n_tag = tg;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fail_line("WATCHDOG", "run did not finish", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (rdrive !== 1'b0) fail_line("R12", "drive in reset", {31'd0, rdrive}, 32'd0);
        rst = 0;
        // no-strobe cycles after reset: no access
        quiet(); n_adv = 0; n_tag = "R12"; step(); step(); step();

        // fill every word with a full-word write
        for (int i = 0; i < DEPTH; i++) ctrl(i[AW-1:0], 0, 1, 4'hF, $urandom, "R6");
        // global write overrides byte controls
        ctrl(8'h10, 0, 0, 4'hF, 32'hA5A5_5A5A, "R6");
        ctrl(8'h10, 1, 1, 4'hF, 32'h0, "R6");
        // partial byte write: lanes 0 and 2
        ctrl(8'h11, 0, 1, 4'hF, 32'h1111_1111, "R7");
        ctrl(8'h11, 1, 0, 4'b1010, 32'hCCDD_EEFF, "R7");
        ctrl(8'h11, 1, 0, 4'hF, 32'h7777_7777, "R7");
        ctrl(8'h11, 1, 1, 4'hF, 32'h0, "R7");
        // both strobes with global write low: read, nothing written
        quiet(); n_sp = 0; n_sc = 0; n_gw = 0; n_addr = 8'h12; n_wd = 32'hDEAD_BEEF; n_tag = "R4"; step();
        ctrl(8'h12, 1, 1, 4'hF, 32'h0, "R4");
        // linear burst from offset 1 with a suspend
        n_lin = 1;
        ctrl(8'h21, 1, 1, 4'hF, 0, "R8");
        cont(0, "R8"); cont(1, "R9"); cont(0, "R8"); cont(0, "R8"); cont(0, "R8");
        // interleaved burst from offset 1
        n_lin = 0;
        ctrl(8'h35, 1, 1, 4'hF, 0, "R8");
        cont(0, "R8"); cont(0, "R8"); cont(0, "R8"); cont(0, "R8");
        // processor strobe with select 1 high mid-burst continues the burst
        quiet(); n_sp = 0; n_s1 = 1; n_adv = 0; n_addr = 8'hF0; n_tag = "R3"; step();
        cont(0, "R3");
        // deselect then read: first cycle not driven
        quiet(); n_sc = 0; n_s2 = 0; n_tag = "R10"; step();
        cont(0, "R10"); cont(0, "R10");
        ctrl(8'h44, 1, 1, 4'hF, 0, "R10");
        quiet(); n_sc = 0; n_s3 = 1; n_tag = "R2"; step();
        ctrl(8'h45, 1, 1, 4'hF, 0, "R2");
        // output enable probing
        probe_oe = 1;
        ctrl(8'h46, 1, 1, 4'hF, 0, "R11"); cont(1, "R11"); cont(0, "R11");
        probe_oe = 0;

        // seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            quiet();
            if (i % 1000 == 0) n_lin = ~n_lin;
            n_sp   = ($urandom_range(99) >= 25);
            n_sc   = ($urandom_range(99) >= 30);
            n_s1   = ($urandom_range(99) >= 85);
            n_s2   = ($urandom_range(99) < 90);
            n_s3   = ($urandom_range(99) >= 90);
            n_adv  = ($urandom_range(99) >= 60);
            n_gw   = ($urandom_range(99) >= 20);
            n_bwe  = ($urandom_range(99) >= 30);
            n_bsel = 4'($urandom);
            n_oe   = ($urandom_range(99) >= 85);
            n_addr = AW'($urandom);
            n_wd   = $urandom;
            probe_oe = ($urandom_range(9) == 0);
            step();
        end
        probe_oe = 0;
        quiet(); step(); step(); step();
        finish_run();
    end
endmodule